// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer with separate write and read clocks. Each data word is 9 bits wide, and the depth is a parameter with a default of 64 words. Besides the full and empty flags, it drives an almost-full flag and an almost-empty flag. The thresholds for these two flags are held in two offset registers inside the block.

The offset registers have no separate access port. They are reached through the ordinary data buses, under a load-select input. When load-select is low, a write-clock edge with the write enable active stores the input word into one offset word. A read-clock edge with both read enables active copies the next offset word onto the read register.

There are two read enables, and a read happens only when both are low. This lets two devices share one read control in a width-expanded arrangement. An output enable releases the data outputs to high impedance. The write and read pointers cross between the clock domains as Gray code through two-flop synchronisers.

Top module: `prog_flag_fifo`

## Requirements
- R1: After reset (rst_n low, asynchronous), the flags are:
  - empty_n = 0
  - full_n = 1
  - paempty_n = 0
  - pafull_n = 1

  The read register holds 0, both offsets are 7, and the offset access position is at word 0. This holds whenever reset is applied, including in the middle of operation.
- R2: With ld_n = 0, wr_en_n = 1 and both read enables low, each read-clock rising edge loads the current offset word into the read register instead of reading the FIFO. The position then advances.
  - Word 0 is empty-offset bits [8:0].
  - Word 1 is empty-offset bits [17:9], which read 0 when the depth is 512 or less.
  - Word 2 is full-offset bits [8:0].
  - Word 3 is full-offset bits [17:9].
  - After word 3 the position wraps to word 0.
- R3: With ld_n = 0 and wr_en_n = 0, each write-clock rising edge stores din into the current offset word and advances the position. Loading and read-back share one position, so a load continues from wherever read-back stopped.
- R4: With ld_n = 1, a write-clock edge with wr_en_n = 0 stores din. A read-clock edge that reads places the oldest stored word on the read register, so words leave in the order they were written.
- R5: A FIFO read or offset read-back needs rd_en_a_n and rd_en_b_n both low. With only one of them low, the read register and the stored contents stay unchanged.
- R6: full_n goes low on the write-clock edge at which DEPTH words are held. A write while full_n is low is discarded.
- R7: A read while empty_n is low changes neither the read register nor the read pointer.
- R8: paempty_n is updated on read-clock edges. It is low when the word count is at most the empty offset n, and high when the count exceeds n.
- R9: pafull_n is updated on write-clock edges. It is high when the number of free locations exceeds the full offset m, and low otherwise.
- R10: With oe_n = 1 the dout pins are high impedance. With oe_n = 0 they drive the read register.
- R11: empty_n rises no earlier than the third read-clock edge after the write edge that stored the first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en_n | input | 1 | Write enable, active low |
| ld_n | input | 1 | Offset access select, active low |
| rd_en_a_n | input | 1 | First read enable, active low |
| rd_en_b_n | input | 1 | Second read enable, active low |
| oe_n | input | 1 | Output enable, active low |
| din | input | DW | Write data or offset word |
| dout | output | DW | Read data, tri-stated when oe_n is high |
| full_n | output | 1 | Full flag, active low |
| empty_n | output | 1 | Empty flag, active low |
| pafull_n | output | 1 | Almost-full flag, active low |
| paempty_n | output | 1 | Almost-empty flag, active low |

## Verification
The assertions check several rules on every cycle:
- A write while full never moves the write pointer.
- A read while empty leaves both the read pointer and the read register unchanged.
- Each offset read-back steps the access position by exactly one.
- full and empty always imply almost-full and almost-empty.
- Offset read-back is never requested during an offset load.

Only the bench scenarios can show the following:
- The rotating offset word order, its wrap, and the shared position between load and read-back.
- The exact threshold crossings at counts n and n+1, and free locations m and m+1.
- The data order through the scoreboard.
- The synchroniser latency before empty_n rises.
- The tri-state release of the output.

// File: rtl/prog_flag_fifo.sv
module prog_flag_fifo #(
  parameter int DW      = 9,
  parameter int DEPTH   = 64,
  parameter int OFS_RST = 7
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          wr_en_n,
  input  logic          ld_n,
  input  logic          rd_en_a_n,
  input  logic          rd_en_b_n,
  input  logic          oe_n,
  input  logic [DW-1:0] din,
  output wire  [DW-1:0] dout,
  output logic          full_n,
  output logic          empty_n,
  output logic          pafull_n,
  output logic          paempty_n
);
  // offsets span two data words, so AW must not exceed 2*DW
  localparam int AW  = $clog2(DEPTH);
  localparam int PW  = AW + 1;
  localparam int OWW = 2 * DW;

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [AW-1:0] put_word(input logic [AW-1:0] cur, input logic hi,
                                             input logic [DW-1:0] d);
    logic [OWW-1:0] w;
    w = OWW'(cur);
    if (hi) w[OWW-1:DW] = d;
    else    w[DW-1:0]   = d;
    return w[AW-1:0];
  endfunction

  function automatic logic [DW-1:0] get_word(input logic [AW-1:0] cur, input logic hi);
    logic [OWW-1:0] w;
    w = OWW'(cur);
    return hi ? w[OWW-1:DW] : w[DW-1:0];
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] ae_ofs, af_ofs;
  logic [1:0]    ofs_wptr, ofs_rptr;
  wire  [1:0]    ofs_sel = ofs_wptr + ofs_rptr;

  // ---------------- write domain ----------------
  logic [PW-1:0] wbin, wgray, rg_s1, rg_s2;
  wire           wr_fifo  = !wr_en_n && ld_n && full_n;
  wire           wr_ofs   = !wr_en_n && !ld_n;
  wire  [PW-1:0] wbin_nxt = wbin + PW'(wr_fifo);
  wire  [PW-1:0] rbin_w   = g2b(rg_s2);
  wire  [PW-1:0] wcnt_nxt = wbin_nxt - rbin_w;
  wire  [PW-1:0] wfree    = PW'(DEPTH) - wcnt_nxt;

  always_ff @(posedge wr_clk)
    if (wr_fifo) mem[wbin[AW-1:0]] <= din;

  always_ff @(posedge wr_clk or negedge rst_n)
    if (!rst_n) begin
      wbin     <= '0;
      wgray    <= '0;
      rg_s1    <= '0;
      rg_s2    <= '0;
      full_n   <= 1'b1;
      pafull_n <= 1'b1;
      ae_ofs   <= AW'(OFS_RST);
      af_ofs   <= AW'(OFS_RST);
      ofs_wptr <= '0;
    end else begin
      wbin     <= wbin_nxt;
      wgray    <= b2g(wbin_nxt);
      rg_s1    <= rgray;
      rg_s2    <= rg_s1;
      full_n   <= wcnt_nxt != PW'(DEPTH);
      pafull_n <= wfree > PW'(af_ofs);
      if (wr_ofs) begin
        ofs_wptr <= ofs_wptr + 2'd1;
        if (!ofs_sel[1]) ae_ofs <= put_word(ae_ofs, ofs_sel[0], din);
        else             af_ofs <= put_word(af_ofs, ofs_sel[0], din);
      end
    end

  // R6
  full_hold_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (!full_n && !wr_en_n && ld_n) |=> $stable(wbin));
  // R9
  full_af_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |-> !pafull_n);

  // ---------------- read domain ----------------
  logic [PW-1:0] rbin, rgray, wg_s1, wg_s2;
  logic [DW-1:0] q;
  wire           rd_both  = !rd_en_a_n && !rd_en_b_n;
  wire           rd_fifo  = rd_both && ld_n && empty_n;
  wire           ofs_rd   = rd_both && !ld_n && wr_en_n;
  wire  [PW-1:0] rbin_nxt = rbin + PW'(rd_fifo);
  wire  [PW-1:0] wbin_r   = g2b(wg_s2);
  wire  [PW-1:0] rcnt_nxt = wbin_r - rbin_nxt;

  always_ff @(posedge rd_clk or negedge rst_n)
    if (!rst_n) begin
      rbin      <= '0;
      rgray     <= '0;
      wg_s1     <= '0;
      wg_s2     <= '0;
      empty_n   <= 1'b0;
      paempty_n <= 1'b0;
      q         <= '0;
      ofs_rptr  <= '0;
    end else begin
      rbin      <= rbin_nxt;
      rgray     <= b2g(rbin_nxt);
      wg_s1     <= wgray;
      wg_s2     <= wg_s1;
      empty_n   <= rcnt_nxt != '0;
      paempty_n <= rcnt_nxt > PW'(ae_ofs);
      if (rd_fifo) q <= mem[rbin[AW-1:0]];
      else if (ofs_rd) begin
        q        <= get_word(ofs_sel[1] ? af_ofs : ae_ofs, ofs_sel[0]);
        ofs_rptr <= ofs_rptr + 2'd1;
      end
    end

  assign dout = oe_n ? 'z : q;

  // R7
  empty_hold_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!empty_n && rd_both && ld_n) |=> ($stable(rbin) && $stable(q)));
  // R8
  empty_ae_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |-> !paempty_n);
  // R2
  ofs_step_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    ofs_rd |=> ofs_rptr == 2'($past(ofs_rptr) + 2'd1));
  // R3
  ofs_clash_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_both && !ld_n) |-> wr_en_n);
endmodule

// File: tb/prog_flag_fifo_bench.sv
module prog_flag_fifo_bench;
  localparam int DEPTH = 64;
  logic wclk = 0, rclk = 0;
  logic rst_n = 0, wr_en_n = 1, ld_n = 1, rd_en_a_n = 1, rd_en_b_n = 1, oe_n = 0;
  logic [8:0] din = '0;
  wire  [8:0] dout;
  wire full_n, empty_n, pafull_n, paempty_n;
  int n_chk = 0, n_bad = 0;
  bit exp_read = 0, done = 0;
  logic [8:0] exp_q[$];

  always #4 wclk = ~wclk;
  always #6 rclk = ~rclk;

  prog_flag_fifo u_prog_flag_fifo (
    .wr_clk(wclk), .rd_clk(rclk), .rst_n(rst_n), .wr_en_n(wr_en_n), .ld_n(ld_n),
    .rd_en_a_n(rd_en_a_n), .rd_en_b_n(rd_en_b_n), .oe_n(oe_n), .din(din), .dout(dout),
    .full_n(full_n), .empty_n(empty_n), .pafull_n(pafull_n), .paempty_n(paempty_n));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rwait(input int n);
    repeat (n) @(negedge rclk);
  endtask

  task automatic wr_word(input logic [8:0] d);
    @(negedge wclk);
    if (exp_q.size() < DEPTH) exp_q.push_back(d);
    din = d; wr_en_n = 0;
    @(negedge wclk);
    wr_en_n = 1;
  endtask

  task automatic ofs_wr(input logic [8:0] d);
    @(negedge wclk);
    ld_n = 0; din = d; wr_en_n = 0;
    @(negedge wclk);
    wr_en_n = 1; ld_n = 1;
  endtask

  task automatic ofs_rd(input logic [8:0] exp, input string req);
    @(negedge rclk);
    ld_n = 0; rd_en_a_n = 0; rd_en_b_n = 0;
    @(negedge rclk);
    rd_en_a_n = 1; rd_en_b_n = 1; ld_n = 1;
    check(dout === exp, req, dout, exp);
  endtask

  task automatic fifo_rd();
    @(negedge rclk);
    exp_read = empty_n;
    rd_en_a_n = 0; rd_en_b_n = 0;
    @(negedge rclk);
    rd_en_a_n = 1; rd_en_b_n = 1; exp_read = 0;
  endtask

  // scoreboard monitor
  initial forever begin
    @(posedge rclk);
    if (exp_read) begin
      logic [8:0] e;
      #2;
      e = exp_q.size() > 0 ? exp_q.pop_front() : 9'h000;
      check(dout === e, "R4 data order", dout, e);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1500000;
    n_bad++;
    $display("FAIL watchdog: got 0 expected 1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge wclk);
    rst_n = 1;
    rwait(2);
    // R1 reset state
    check(empty_n === 0, "R1 empty_n", empty_n, 0);
    check(full_n === 1, "R1 full_n", full_n, 1);
    check(paempty_n === 0, "R1 paempty_n", paempty_n, 0);
    check(pafull_n === 1, "R1 pafull_n", pafull_n, 1);
    check(dout === 9'h000, "R1 dout", dout, 0);
    // R1/R2 default offsets in word order
    ofs_rd(9'd7, "R1 ae lsb"); ofs_rd(9'd0, "R2 ae msb");
    ofs_rd(9'd7, "R1 af lsb"); ofs_rd(9'd0, "R2 af msb");
    // R3 load n=3, m=5
    ofs_wr(9'd3); ofs_wr(9'd0); ofs_wr(9'd5); ofs_wr(9'd0);
    ofs_rd(9'd3, "R3 ae lsb"); ofs_rd(9'd0, "R3 ae msb");
    ofs_rd(9'd5, "R3 af lsb"); ofs_rd(9'd0, "R3 af msb");
    ofs_rd(9'd3, "R2 wrap to word 0");
    ofs_wr(9'd0);                         // R3 shared position: writes word 1
    ofs_rd(9'd5, "R3 shared position");   // word 2
    ofs_rd(9'd0, "R2 word 3");
    // R11 latency, R5 dual enables
    wr_word(9'h1A5);
    @(negedge rclk);
    check(empty_n === 0, "R11 empty latency", empty_n, 0);
    rwait(6);
    check(empty_n === 1, "R4 empty_n after write", empty_n, 1);
    @(negedge rclk); rd_en_a_n = 0; @(negedge rclk); rd_en_a_n = 1;
    @(negedge rclk); rd_en_b_n = 0; @(negedge rclk); rd_en_b_n = 1;
    rwait(2);
    check(empty_n === 1, "R5 single enable no read", empty_n, 1);
    check(dout === 9'h000, "R5 dout held", dout, 0);
    fifo_rd();
    rwait(2);
    check(empty_n === 0, "R4 empty after last read", empty_n, 0);
    // R10 output enable
    oe_n = 1; #1;
    check(dout === 9'bz || dout === 9'h000, "R10 high impedance", dout, 0);
    oe_n = 0; #1;
    check(dout === 9'h1A5, "R10 drive", dout, 9'h1A5);
    // R7 read while empty
    @(negedge rclk); rd_en_a_n = 0; rd_en_b_n = 0;
    @(negedge rclk); rd_en_a_n = 1; rd_en_b_n = 1;
    rwait(2);
    check(dout === 9'h1A5, "R7 empty read ignored", dout, 9'h1A5);
    check(empty_n === 0, "R7 still empty", empty_n, 0);
    // R8 almost-empty threshold n=3
    for (int i = 0; i < 3; i++) wr_word(9'((i * 37 + 11) & 9'h1FF));
    rwait(8);
    check(paempty_n === 0, "R8 count 3 <= n", paempty_n, 0);
    wr_word(9'h0AA);
    rwait(8);
    check(paempty_n === 1, "R8 count 4 > n", paempty_n, 1);
    // R9 almost-full threshold m=5
    for (int i = 4; i < 58; i++) wr_word(9'((i * 37 + 11) & 9'h1FF));
    check(pafull_n === 1, "R9 free 6 > m", pafull_n, 1);
    wr_word(9'h155);
    check(pafull_n === 0, "R9 free 5 <= m", pafull_n, 0);
    // R6 full and overflow
    for (int i = 59; i < 64; i++) wr_word(9'((i * 53 + 7) & 9'h1FF));
    check(full_n === 0, "R6 full at DEPTH", full_n, 0);
    wr_word(9'h1FF);
    check(full_n === 0, "R6 still full", full_n, 0);
    rwait(8);
    for (int i = 0; i < 64; i++) fifo_rd();
    rwait(4);
    check(empty_n === 0, "R6 overflow word discarded", empty_n, 0);
    check(exp_q.size() == 0, "R6 queue drained", exp_q.size(), 0);
    // R1 reset mid-operation
    wr_word(9'h033); wr_word(9'h044);
    ofs_wr(9'd12);
    rwait(8);
    @(negedge wclk); rst_n = 0; exp_q.delete();
    @(negedge wclk); rst_n = 1;
    rwait(2);
    check(empty_n === 0, "R1 reset empty_n", empty_n, 0);
    check(full_n === 1, "R1 reset full_n", full_n, 1);
    check(paempty_n === 0, "R1 reset paempty_n", paempty_n, 0);
    ofs_rd(9'd7, "R1 reset restores offset");
    finish_run();
  end
endmodule